// File: doc/BRIEF.md
# DMA Address and Byte Counter

This block tracks the address and the remaining byte count for a pair of bus-master DMA directions: one that reads from the bus and one that writes to it. Software loads a start address and a byte count for each direction through a small register write port. After that, the block advances the address and reduces the count each time the data path reports a finished access. Bus signalling and FIFO storage are handled outside this block.

One shared enable turns byte counting on or off for both directions together. While counting is off, the counts are frozen and every access is a full bus word. While counting is on, a direction whose count has reached zero raises its terminal-count flag and refuses further accesses. If that direction's interrupt enable is set, the block also latches an interrupt at the moment the count reaches zero. When fewer than a full word of bytes remain, the byte enables mark only the low lanes that still hold valid data, so a transfer may end on any byte.

Completions arrive on a valid/ready channel. `done_valid` carries the direction and the number of bytes moved. `done_ready` is high unless the selected direction is at terminal count. A completion counts only in a cycle where both are high. A source may hold `done_valid` while `done_ready` is low, and it may change `done_dir` while it waits.

Top module: `dma_addr_counter`

## Requirements
- R1: After reset, both addresses, both counts and both interrupts are zero.
- R2: A load of either address register clears the low two bits of the stored address, so stored addresses are always word aligned.
- R3: Each accepted completion adds 4 to the address of its own direction and leaves the other direction's address unchanged. `done_dir` is 0 for the read direction and 1 for the write direction.
- R4: With counting enabled, each accepted completion lowers its direction's count by `done_bytes` (1 to 4). The count stops at zero if `done_bytes` exceeds it.
- R5: Byte enable bit i (bit 0 = lowest-addressed byte) is set when counting is disabled or when the count is greater than i. A count of 1 to 3 therefore gives the low 1 to 3 lanes, and a count of 0 with counting enabled gives 0000.
- R6: With counting disabled, accepted completions leave both counts unchanged and still advance the addresses.
- R7: A direction's terminal-count flag is high exactly when counting is enabled and its count is zero. `done_ready` is low exactly when the direction selected by `done_dir` has its terminal-count flag high.
- R8: A direction's interrupt sets when counting is enabled, that direction's interrupt enable is high, and an accepted completion takes its count from nonzero to zero. It stays set until a clear write with `irq_clr` bit 0 (read) or bit 1 (write) set. If a set and a clear happen in the same cycle, the set wins.
- R9: `cfg_addr` selects 0 = read address, 1 = read count, 2 = write address, 3 = write count. When a register load and an accepted completion update the same register in the same cycle, the loaded value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register load strobe |
| cfg_addr | input | 2 | Register select (see R9) |
| cfg_wdata | input | ADDR_W | Load value |
| irq_clr_we | input | 1 | Interrupt clear strobe |
| irq_clr | input | 2 | Write-one-to-clear mask, bit 0 read, bit 1 write |
| count_en | input | 1 | Shared byte-count enable for both directions |
| rd_irq_en | input | 1 | Read direction interrupt enable |
| wr_irq_en | input | 1 | Write direction interrupt enable |
| done_valid | input | 1 | Completion offered |
| done_dir | input | 1 | Completion direction, 0 read, 1 write |
| done_bytes | input | 3 | Bytes moved by the completion, 1 to 4 |
| done_ready | output | 1 | Completion accepted when high together with done_valid |
| rd_addr | output | ADDR_W | Next read address |
| rd_count | output | CNT_W | Remaining read bytes |
| rd_be | output | 4 | Read byte enables for the next access |
| rd_tc | output | 1 | Read terminal count |
| rd_irq | output | 1 | Latched read interrupt |
| wr_addr | output | ADDR_W | Next write address |
| wr_count | output | CNT_W | Remaining write bytes |
| wr_be | output | 4 | Write byte enables for the next access |
| wr_tc | output | 1 | Write terminal count |
| wr_irq | output | 1 | Latched write interrupt |

## Verification
The assertions assume that `done_bytes` lies between 1 and 4 whenever `done_valid` is high. The stimulus always draws it from that range, including values larger than the remaining count so that the stop at zero is exercised. The address-step property excludes cycles in which software loads that same address register, because the load takes priority there. The stimulus creates such collisions on purpose, and also sets and clears an interrupt in the same cycle. The shared enable is switched both while counts are nonzero and while they are zero, so the byte-enable and terminal-count properties are checked in each combination.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    SEL_RD_ADDR = 2'd0,
    SEL_RD_CNT  = 2'd1,
    SEL_WR_ADDR = 2'd2,
    SEL_WR_CNT  = 2'd3
  } cfg_sel_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_RD  = 0;
  localparam int unsigned DIR_WR  = 1;
endpackage

// File: rtl/dmac_be_gen.sv
module dmac_be_gen #(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned BUS_BYTES = 4
) (
  input  logic [CNT_W-1:0]     count,
  input  logic                 count_en,
  output logic [BUS_BYTES-1:0] be
);
  // One comparator per byte lane: lane i carries data while more than i bytes remain.
  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign be[i] = !count_en || (count > CNT_W'(i));
  end
endmodule

// File: rtl/dmac_irq_latch.sv
module dmac_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned BUS_BYTES = 4,
  localparam int unsigned LANE_W   = $clog2(BUS_BYTES),
  localparam int unsigned BYTES_W  = LANE_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_addr,
  input  logic                 ld_cnt,
  input  logic [ADDR_W-1:0]    ld_data,
  input  logic                 step,
  input  logic                 count_en,
  input  logic [BYTES_W-1:0]   step_bytes,
  output logic [ADDR_W-1:0]    addr,
  output logic [CNT_W-1:0]     count,
  output logic [BUS_BYTES-1:0] be,
  output logic                 tc,
  output logic                 hit_zero
);
  logic [CNT_W-1:0] step_ext;
  logic             last_step;
  logic [CNT_W-1:0] cnt_after;

  assign step_ext  = CNT_W'(step_bytes);
  assign last_step = (count <= step_ext);
  assign cnt_after = last_step ? '0 : (count - step_ext);
  assign tc        = count_en && (count == '0);
  assign hit_zero  = step && count_en && (count != '0) && last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (ld_addr) begin
      addr <= {ld_data[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    end else if (step) begin
      addr <= addr + ADDR_W'(BUS_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (ld_cnt) begin
      count <= ld_data[CNT_W-1:0];
    end else if (step && count_en) begin
      count <= cnt_after;
    end
  end

  dmac_be_gen #(.CNT_W(CNT_W), .BUS_BYTES(BUS_BYTES)) u_be (
    .count    (count),
    .count_en (count_en),
    .be       (be)
  );
endmodule

// File: rtl/dma_addr_counter.sv
module dma_addr_counter
  import dmac_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned BUS_BYTES = 4,
  localparam int unsigned LANE_W   = $clog2(BUS_BYTES),
  localparam int unsigned BYTES_W  = LANE_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  input  logic                 irq_clr_we,
  input  logic [1:0]           irq_clr,
  input  logic                 count_en,
  input  logic                 rd_irq_en,
  input  logic                 wr_irq_en,
  input  logic                 done_valid,
  input  logic                 done_dir,
  input  logic [BYTES_W-1:0]   done_bytes,
  output logic                 done_ready,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic [CNT_W-1:0]     rd_count,
  output logic [BUS_BYTES-1:0] rd_be,
  output logic                 rd_tc,
  output logic                 rd_irq,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [CNT_W-1:0]     wr_count,
  output logic [BUS_BYTES-1:0] wr_be,
  output logic                 wr_tc,
  output logic                 wr_irq
);
  logic [NUM_DIR-1:0][ADDR_W-1:0]    ch_addr;
  logic [NUM_DIR-1:0][CNT_W-1:0]     ch_count;
  logic [NUM_DIR-1:0][BUS_BYTES-1:0] ch_be;
  logic [NUM_DIR-1:0]                ch_tc;
  logic [NUM_DIR-1:0]                ch_zero;
  logic [NUM_DIR-1:0]                ch_irq;
  logic [NUM_DIR-1:0]                irq_en;
  cfg_sel_e                          sel;

  assign sel        = cfg_sel_e'(cfg_addr);
  assign irq_en     = {wr_irq_en, rd_irq_en};
  assign done_ready = !ch_tc[done_dir];

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam cfg_sel_e SEL_A = (d == DIR_RD) ? SEL_RD_ADDR : SEL_WR_ADDR;
    localparam cfg_sel_e SEL_C = (d == DIR_RD) ? SEL_RD_CNT  : SEL_WR_CNT;
    logic step;
    assign step = done_valid && done_ready && (done_dir == 1'(d));

    dmac_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_BYTES(BUS_BYTES)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_addr    (cfg_we && (sel == SEL_A)),
      .ld_cnt     (cfg_we && (sel == SEL_C)),
      .ld_data    (cfg_wdata),
      .step       (step),
      .count_en   (count_en),
      .step_bytes (done_bytes),
      .addr       (ch_addr[d]),
      .count      (ch_count[d]),
      .be         (ch_be[d]),
      .tc         (ch_tc[d]),
      .hit_zero   (ch_zero[d])
    );

    dmac_irq_latch u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ch_zero[d] && irq_en[d]),
      .clr   (irq_clr_we && irq_clr[d]),
      .q     (ch_irq[d])
    );
  end

  assign rd_addr  = ch_addr[DIR_RD];
  assign rd_count = ch_count[DIR_RD];
  assign rd_be    = ch_be[DIR_RD];
  assign rd_tc    = ch_tc[DIR_RD];
  assign rd_irq   = ch_irq[DIR_RD];
  assign wr_addr  = ch_addr[DIR_WR];
  assign wr_count = ch_count[DIR_WR];
  assign wr_be    = ch_be[DIR_WR];
  assign wr_tc    = ch_tc[DIR_WR];
  assign wr_irq   = ch_irq[DIR_WR];
endmodule

// File: rtl/dma_addr_counter_chk.sv
module dma_addr_counter_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned BUS_BYTES = 4,
  localparam int unsigned BYTES_W  = $clog2(BUS_BYTES) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [1:0]           cfg_addr,
  input logic                 irq_clr_we,
  input logic [1:0]           irq_clr,
  input logic                 count_en,
  input logic                 done_valid,
  input logic                 done_dir,
  input logic [BYTES_W-1:0]   done_bytes,
  input logic                 done_ready,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic [CNT_W-1:0]     rd_count,
  input logic [BUS_BYTES-1:0] rd_be,
  input logic                 rd_tc,
  input logic                 rd_irq,
  input logic [ADDR_W-1:0]    wr_addr
);
  AST_RD_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr[1:0] == 2'b00); // R2
  AST_WR_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr[1:0] == 2'b00); // R2
  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_ready && !done_dir && !(cfg_we && cfg_addr == 2'd0))
    |=> rd_addr == $past(rd_addr) + ADDR_W'(4)); // R3
  AST_WR_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(done_valid && done_ready && done_dir) && !(cfg_we && cfg_addr == 2'd2))
    |=> $stable(wr_addr)); // R3
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !cfg_we) |=> $stable(rd_count)); // R6
  AST_BE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && rd_count == CNT_W'(1)) |-> rd_be == 4'b0001); // R5
  AST_READY_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tc && !done_dir) |-> !done_ready); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_irq && !(irq_clr_we && irq_clr[0])) |=> rd_irq); // R8
  AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_bytes >= BYTES_W'(1) && done_bytes <= BYTES_W'(BUS_BYTES))); // R4
endmodule

bind dma_addr_counter dma_addr_counter_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_BYTES(BUS_BYTES)
) u_chk (.*);

// File: tb/dma_addr_counter_test.sv
module dma_addr_counter_test;
  localparam int AW = 32;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic          irq_clr_we;
  logic [1:0]    irq_clr;
  logic          count_en, rd_irq_en, wr_irq_en;
  logic          done_valid, done_dir;
  logic [2:0]    done_bytes;
  logic          done_ready;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [CW-1:0] rd_count, wr_count;
  logic [3:0]    rd_be, wr_be;
  logic          rd_tc, wr_tc, rd_irq, wr_irq;

  always #2 clk = ~clk;

  dma_addr_counter uut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [AW-1:0] m_addr [2];
  logic [CW-1:0] m_cnt  [2];
  bit            m_irq  [2];

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string atag, string ctag);
    for (int d = 0; d < 2; d++) begin
      logic [3:0] exp_be;
      exp_be = 4'hF;
      if (count_en && m_cnt[d] < 4) exp_be = 4'((1 << m_cnt[d]) - 1);
      chk(atag, d ? "wr_addr" : "rd_addr", d ? wr_addr : rd_addr, m_addr[d]);
      chk(ctag, d ? "wr_count" : "rd_count", d ? wr_count : rd_count, m_cnt[d]);
      chk("R5", d ? "wr_be" : "rd_be", d ? wr_be : rd_be, exp_be);
      chk("R7", d ? "wr_tc" : "rd_tc", d ? wr_tc : rd_tc, count_en && m_cnt[d] == 0);
      chk("R8", d ? "wr_irq" : "rd_irq", d ? wr_irq : rd_irq, m_irq[d]);
    end
    chk("R7", "done_ready", done_ready, !(count_en && m_cnt[done_dir] == 0));
  endtask

  task automatic step(bit we, logic [1:0] sel, logic [AW-1:0] wd, bit cw, logic [1:0] cb,
                      bit dv, bit dd, logic [2:0] db, string atag = "R3", string ctag = "R4");
    logic [AW-1:0] na [2];
    logic [CW-1:0] nc [2];
    bit            ni [2];
    bit            acc;
    cfg_we = we; cfg_addr = sel; cfg_wdata = wd;
    irq_clr_we = cw; irq_clr = cb;
    done_valid = dv; done_dir = dd; done_bytes = db;
    acc = dv && !(count_en && m_cnt[dd] == 0);
    for (int d = 0; d < 2; d++) begin
      bit ien, setv;
      ien = d ? wr_irq_en : rd_irq_en;
      na[d] = m_addr[d]; nc[d] = m_cnt[d]; ni[d] = m_irq[d]; setv = 0;
      if (acc && dd == d) begin
        na[d] = m_addr[d] + 4;
        if (count_en) begin
          nc[d] = (db >= m_cnt[d]) ? '0 : m_cnt[d] - db;
          setv = ien && m_cnt[d] != 0 && nc[d] == 0;
        end
      end
      if (setv) ni[d] = 1;
      else if (cw && cb[d]) ni[d] = 0;
      if (we && sel == 2'(2 * d))     na[d] = wd & ~AW'(3);
      if (we && sel == 2'(2 * d + 1)) nc[d] = wd[CW-1:0];
    end
    @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      m_addr[d] = na[d]; m_cnt[d] = nc[d]; m_irq[d] = ni[d];
    end
    compare(atag, ctag);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, done_dir, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; irq_clr_we = 0; irq_clr = 0;
    count_en = 0; rd_irq_en = 0; wr_irq_en = 0; done_valid = 0; done_dir = 0; done_bytes = 1;
    for (int d = 0; d < 2; d++) begin m_addr[d] = 0; m_cnt[d] = 0; m_irq[d] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1", "R1");
    chk("R1", "rd_irq", rd_irq, 0);
    chk("R1", "wr_irq", wr_irq, 0);

    // R2: unaligned loads are word aligned
    step(1, 2'd0, 32'h0000_1003, 0, 0, 0, 0, 1, "R2");
    step(1, 2'd2, 32'h0000_2006, 0, 0, 0, 0, 1, "R2");
    step(1, 2'd1, 32'd10, 0, 0, 0, 0, 1);
    step(1, 2'd3, 32'd7, 0, 0, 0, 0, 1);

    // R4/R5/R8: read channel counts down to zero with a partial last word
    count_en = 1; rd_irq_en = 1; wr_irq_en = 1;
    idle();
    step(0, 0, 0, 0, 0, 1, 0, 4);
    step(0, 0, 0, 0, 0, 1, 0, 4);
    step(0, 0, 0, 0, 0, 1, 0, 2);
    // R7: completion at terminal count is refused
    step(0, 0, 0, 0, 0, 1, 0, 4, "R7", "R7");
    // write channel: 4 then oversized 4 (clamps at zero)
    step(0, 0, 0, 0, 0, 1, 1, 4);
    step(0, 0, 0, 0, 0, 1, 1, 4);
    // R8: clear read interrupt
    step(0, 0, 0, 1, 2'b01, 0, 0, 1);
    // R8: set and clear in the same cycle, set wins
    step(1, 2'd3, 32'd3, 0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 2'b10, 1, 1, 3);
    step(0, 0, 0, 1, 2'b11, 0, 1, 1);
    // R6: counting disabled, counts frozen, addresses move
    count_en = 0;
    step(1, 2'd1, 32'd9, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1, 0, 4, "R3", "R6");
    step(0, 0, 0, 0, 0, 1, 1, 2, "R3", "R6");
    // R9: load collides with completion on the same register
    count_en = 1;
    step(1, 2'd0, 32'h0000_4000, 0, 0, 1, 0, 4, "R9", "R4");
    step(1, 2'd1, 32'd20, 0, 0, 1, 0, 4, "R3", "R9");

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) count_en = ~count_en;
      if (r >= 3 && r < 6) rd_irq_en = ~rd_irq_en;
      if (r >= 6 && r < 8) wr_irq_en = ~wr_irq_en;
      step($urandom_range(0, 9) == 0, 2'($urandom_range(0, 3)), 32'($urandom_range(0, 40)),
           $urandom_range(0, 7) == 0, 2'($urandom_range(0, 3)),
           $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)), 3'($urandom_range(1, 4)));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule